// File: doc/BRIEF.md
# SCSI Host DMA Channel Controller

This block is the register file and transfer bookkeeping engine of one DMA channel in a SCSI host adapter. Software programs a starting count, a starting address and a starting descriptor address. It then writes a command word whose two low bits choose one of four operations. The START operation copies all three starting values into their working copies in one cycle, clears the stored status flags and turns on the DMA enable toward the SCSI core.

While a transfer runs, the SCSI core offers data chunks with a direction and a requested length. The block drops a chunk whose direction disagrees with the programmed direction. Otherwise it grants the smaller of the request and the remaining working count, then lowers the count and raises the working address by the granted amount. The length is only reported; the memory bus master sits elsewhere. When the count runs out, or when the core signals command completion, a done flag is set. That flag and the core's interrupt line drive the interrupt output.

Status flags are cleared in one of two ways, selected by a mode bit in a separate bus-control register. In one mode software writes ones to clear them. In the other mode reading the status register clears them.

Top module: `hba_dma_channel`

## Requirements
- R1: After reset the command register reads 0, the working count reads 0, the working address reads 0xFFFFFFFF, the working descriptor address reads 0xFFFFFFFD, the stored status flags read 0, the bus-control register reads 0, and dma_en and abort_pulse are 0.
- R2: A write to index 0 stores the whole word as the command. Bits [1:0] select the operation, decoded as 0 IDLE, 1 flush, 2 ABORT, 3 START. IDLE clears dma_en on the next edge and START sets it. The flush code changes nothing except the stored command. ABORT raises abort_pulse for exactly the one cycle after the write.
- R3: START loads the working count (index 3) from the starting count (index 1), the working address (index 4) from the starting address (index 2), and the working descriptor address (index 7) from the starting descriptor address (index 6), all on the same edge. It also clears status bits 0 to 5.
- R4: Indices 1, 2, 6 and 8 are writable and read back what was written. Writes to indices 3, 4 and 7 leave those registers unchanged. Index 9 and above read as 0.
- R5: When bus-control bit 12 is 0, a write to the status register (index 5) clears each of status bits 1, 2 and 3 whose written bit is 1. A read has no side effect in this mode.
- R6: When bus-control bit 12 is 1, writes to the status register are ignored. A read with reg_rd high returns the current value and clears bits 1 to 3 on that edge.
- R7: Status bit 4 reads as 1 in the same cycle that core_irq is 1, and it is never stored.
- R8: A transfer request whose xfer_dir differs from command bit 7 gets no grant (1 means device to memory).
- R9: A granted length equals the smaller of xfer_len and the working count. On the edge, the working count decreases by that amount and the working address increases by it.
- R10: Status bit 3 (done) is set when a grant brings the working count to 0. It is also set when core_done is high; in that case the working count is forced to 0.
- R11: irq is high whenever core_irq is high, or when done (status bit 3) and command bit 6 are both 1.
- R12: Within one cycle: a command write drops any transfer request; START overrides core_done and clears status; a done event beats a status clear from a write or a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used only for read-to-clear) |
| reg_idx | input | 4 | Register index, 0 to 7 channel registers, 8 bus control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx, combinational |
| core_irq | input | 1 | Interrupt status of the SCSI core |
| core_done | input | 1 | Command completion pulse from the SCSI core |
| xfer_req | input | 1 | Transfer chunk request from the core |
| xfer_dir | input | 1 | Chunk direction, 1 device to memory |
| xfer_len | input | 32 | Requested chunk length |
| xfer_grant | output | 1 | Chunk accepted this cycle |
| xfer_grant_len | output | 32 | Granted chunk length |
| dma_en | output | 1 | DMA enable toward the core |
| abort_pulse | output | 1 | One-cycle request cancel |
| irq | output | 1 | Channel interrupt |

## Verification
The collision that matters is a done event and a status clear landing on the same edge. The done event comes either from a grant that drains the count or from core_done. The clear comes either from a write of ones or from a read in read-to-clear mode. The bench sets this up in directed steps, and the random phase also keeps counts small and fires core_done often enough that the two meet repeatedly. A reference model in the bench applies the clear first and the set second, and the status read in the following cycle must show done still set. START arriving together with core_done is judged the same way: the working count must equal the starting count, not zero.

// File: rtl/hba_dma_pkg.sv
package hba_dma_pkg;

  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    RI_CMD   = 4'd0,
    RI_SCNT  = 4'd1,
    RI_SADR  = 4'd2,
    RI_WCNT  = 4'd3,
    RI_WADR  = 4'd4,
    RI_STAT  = 4'd5,
    RI_SDESC = 4'd6,
    RI_WDESC = 4'd7,
    RI_BCTL  = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int STAT_W      = 8;
  localparam int ST_DONE     = 3;
  localparam int ST_CORE_INT = 4;
  localparam int CMD_DONE_IE = 6;
  localparam int CMD_DIR     = 7;

endpackage

// File: rtl/hba_dma_cmd_dec.sv
module hba_dma_cmd_dec
  import hba_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] op_bits,
  output logic       start_fire,
  output logic       dma_en,
  output logic       abort_pulse
);

  dma_op_e op;
  logic    idle_fire;
  logic    abort_fire;

  assign op         = dma_op_e'(op_bits);
  assign start_fire = cmd_wr && (op == OP_START);
  assign idle_fire  = cmd_wr && (op == OP_IDLE);
  assign abort_fire = cmd_wr && (op == OP_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en      <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= abort_fire;
      if (start_fire)     dma_en <= 1'b1;
      else if (idle_fire) dma_en <= 1'b0;
    end
  end

endmodule

// File: rtl/hba_dma_xfer.sv
module hba_dma_xfer #(
  parameter int DATA_W = 32
) (
  input  logic              req,
  input  logic              dir,
  input  logic              cmd_dir,
  input  logic              blocked,
  input  logic [DATA_W-1:0] len,
  input  logic [DATA_W-1:0] wcnt,
  output logic              grant,
  output logic [DATA_W-1:0] grant_len,
  output logic              drains
);

  function automatic logic [DATA_W-1:0] clamp_len(
    input logic [DATA_W-1:0] want,
    input logic [DATA_W-1:0] left
  );
    return (want < left) ? want : left;
  endfunction

  assign grant     = req && (dir == cmd_dir) && !blocked;
  assign grant_len = clamp_len(len, wcnt);
  assign drains    = grant && (grant_len == wcnt);

endmodule

// File: rtl/hba_dma_stat.sv
module hba_dma_stat
  import hba_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_clr,
  input  logic [2:0]        wr_clr,
  input  logic              rd_clr,
  input  logic              done_set,
  output logic [STAT_W-1:0] stat
);

  logic [2:0]        clr_bits;
  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] set_mask;

  assign clr_bits = wr_clr | {3{rd_clr}};
  assign clr_mask = {{(STAT_W-4){1'b0}}, clr_bits, 1'b0};
  assign set_mask = {{(STAT_W-ST_DONE-1){1'b0}}, done_set, {ST_DONE{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else if (start_clr) begin
      stat <= stat & ~{{(STAT_W-6){1'b0}}, 6'h3F};
    end else begin
      stat <= (stat & ~clr_mask) | set_mask;
    end
  end

endmodule

// File: rtl/hba_dma_channel.sv
module hba_dma_channel
  import hba_dma_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              MODE_BIT  = 12,
  parameter logic [DATA_W-1:0] WADR_RST  = {DATA_W{1'b1}},
  parameter logic [DATA_W-1:0] WDESC_RST = {{(DATA_W-2){1'b1}}, 2'b01}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              core_irq,
  input  logic              core_done,
  input  logic              xfer_req,
  input  logic              xfer_dir,
  input  logic [DATA_W-1:0] xfer_len,
  output logic              xfer_grant,
  output logic [DATA_W-1:0] xfer_grant_len,
  output logic              dma_en,
  output logic              abort_pulse,
  output logic              irq
);

  localparam int PAD_W = DATA_W - STAT_W;

  logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdesc_q;
  logic [DATA_W-1:0] wcnt_q, wadr_q, wdesc_q, bctl_q;
  logic [STAT_W-1:0] stat;
  logic [STAT_W-1:0] stat_live;

  // named internal events
  logic       cmd_wr;
  logic       stat_hit;
  logic       start_fire;
  logic       rd_clear_mode;
  logic [2:0] stat_wr_clr;
  logic       stat_rd_clr;
  logic       drains;
  logic       done_set;

  assign cmd_wr        = reg_wr && (reg_idx == RI_CMD);
  assign stat_hit      = (reg_idx == RI_STAT);
  assign rd_clear_mode = bctl_q[MODE_BIT];
  assign stat_wr_clr   = (reg_wr && stat_hit && !rd_clear_mode) ? reg_wdata[3:1] : 3'b000;
  assign stat_rd_clr   = reg_rd && stat_hit && rd_clear_mode;

  hba_dma_cmd_dec u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .op_bits     (reg_wdata[1:0]),
    .start_fire  (start_fire),
    .dma_en      (dma_en),
    .abort_pulse (abort_pulse)
  );

  hba_dma_xfer #(.DATA_W(DATA_W)) u_xfer (
    .req       (xfer_req),
    .dir       (xfer_dir),
    .cmd_dir   (cmd_q[CMD_DIR]),
    .blocked   (cmd_wr),
    .len       (xfer_len),
    .wcnt      (wcnt_q),
    .grant     (xfer_grant),
    .grant_len (xfer_grant_len),
    .drains    (drains)
  );

  assign done_set = !start_fire && (core_done || drains);

  hba_dma_stat u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_clr (start_fire),
    .wr_clr    (stat_wr_clr),
    .rd_clr    (stat_rd_clr),
    .done_set  (done_set),
    .stat      (stat)
  );

  // software-writable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      scnt_q  <= '0;
      sadr_q  <= '0;
      sdesc_q <= '0;
      bctl_q  <= '0;
    end else if (reg_wr) begin
      case (reg_idx)
        RI_CMD:   cmd_q   <= reg_wdata;
        RI_SCNT:  scnt_q  <= reg_wdata;
        RI_SADR:  sadr_q  <= reg_wdata;
        RI_SDESC: sdesc_q <= reg_wdata;
        RI_BCTL:  bctl_q  <= reg_wdata;
        default:  ;
      endcase
    end
  end

  // working registers, hardware-owned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      wadr_q  <= WADR_RST;
      wdesc_q <= WDESC_RST;
    end else if (start_fire) begin
      wcnt_q  <= scnt_q;
      wadr_q  <= sadr_q;
      wdesc_q <= sdesc_q;
    end else begin
      if (core_done)       wcnt_q <= '0;
      else if (xfer_grant) wcnt_q <= wcnt_q - xfer_grant_len;
      if (xfer_grant)      wadr_q <= wadr_q + xfer_grant_len;
    end
  end

  always_comb begin
    stat_live              = stat;
    stat_live[ST_CORE_INT] = stat[ST_CORE_INT] | core_irq;
  end

  always_comb begin
    case (reg_idx)
      RI_CMD:   reg_rdata = cmd_q;
      RI_SCNT:  reg_rdata = scnt_q;
      RI_SADR:  reg_rdata = sadr_q;
      RI_WCNT:  reg_rdata = wcnt_q;
      RI_WADR:  reg_rdata = wadr_q;
      RI_STAT:  reg_rdata = {{PAD_W{1'b0}}, stat_live};
      RI_SDESC: reg_rdata = sdesc_q;
      RI_WDESC: reg_rdata = wdesc_q;
      RI_BCTL:  reg_rdata = bctl_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = core_irq || (stat[ST_DONE] && cmd_q[CMD_DONE_IE]);

endmodule

// File: rtl/hba_dma_channel_chk.sv
module hba_dma_channel_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_fire,
  input logic              core_done,
  input logic              stat_rd_clr,
  input logic              xfer_grant,
  input logic              xfer_dir,
  input logic [DATA_W-1:0] xfer_grant_len,
  input logic [DATA_W-1:0] cmd_q,
  input logic [DATA_W-1:0] scnt_q,
  input logic [DATA_W-1:0] sadr_q,
  input logic [DATA_W-1:0] sdesc_q,
  input logic [DATA_W-1:0] wcnt_q,
  input logic [DATA_W-1:0] wadr_q,
  input logic [DATA_W-1:0] wdesc_q,
  input logic [7:0]        stat,
  input logic              irq
);

  // R9
  grant_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_grant |-> (xfer_grant_len <= wcnt_q));

  // R8
  grant_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_grant |-> (xfer_dir == cmd_q[7]));

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (wcnt_q == $past(scnt_q)) && (wadr_q == $past(sadr_q))
                   && (wdesc_q == $past(sdesc_q)) && (stat[5:0] == 6'd0));

  // R10
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !start_fire) |=> (stat[3] && (wcnt_q == '0)));

  // R11
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[3] && cmd_q[6]) |-> irq);

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_clr && !core_done && !xfer_grant) |=> (stat[3:1] == 3'b000));

endmodule

bind hba_dma_channel hba_dma_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_fire     (start_fire),
  .core_done      (core_done),
  .stat_rd_clr    (stat_rd_clr),
  .xfer_grant     (xfer_grant),
  .xfer_dir       (xfer_dir),
  .xfer_grant_len (xfer_grant_len),
  .cmd_q          (cmd_q),
  .scnt_q         (scnt_q),
  .sadr_q         (sadr_q),
  .sdesc_q        (sdesc_q),
  .wcnt_q         (wcnt_q),
  .wadr_q         (wadr_q),
  .wdesc_q        (wdesc_q),
  .stat           (stat),
  .irq            (irq)
);

// File: tb/hba_dma_channel_tb.sv
module hba_dma_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_irq = 1'b0, core_done = 1'b0;
  logic        xfer_req = 1'b0, xfer_dir = 1'b0;
  logic [31:0] xfer_len = '0;
  logic        xfer_grant;
  logic [31:0] xfer_grant_len;
  logic        dma_en, abort_pulse, irq;

  always #4 clk = ~clk;

  hba_dma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_irq(core_irq), .core_done(core_done), .xfer_req(xfer_req),
    .xfer_dir(xfer_dir), .xfer_len(xfer_len), .xfer_grant(xfer_grant),
    .xfer_grant_len(xfer_grant_len), .dma_en(dma_en),
    .abort_pulse(abort_pulse), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit over  = 0;

  // reference model state
  logic [31:0] m_cmd, m_scnt, m_sadr, m_wcnt, m_wadr, m_sdesc, m_wdesc, m_bctl;
  logic [7:0]  m_stat;
  logic        m_en, m_abort;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] min_len(input logic [31:0] a, input logic [31:0] b);
    if (b < a) return b;
    return a;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] idx, input logic ci);
    case (idx)
      4'd0: return m_cmd;
      4'd1: return m_scnt;
      4'd2: return m_sadr;
      4'd3: return m_wcnt;
      4'd4: return m_wadr;
      4'd5: return {24'd0, m_stat | {3'b000, ci, 4'b0000}};
      4'd6: return m_sdesc;
      4'd7: return m_wdesc;
      4'd8: return m_bctl;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_scnt = 0; m_sadr = 0; m_sdesc = 0; m_bctl = 0;
    m_wcnt = 0; m_wadr = 32'hFFFF_FFFF; m_wdesc = 32'hFFFF_FFFD;
    m_stat = 0; m_en = 0; m_abort = 0;
  endtask

  task automatic step(input logic wr, input logic rd, input logic [3:0] idx,
                      input logic [31:0] wd, input logic ci, input logic cd,
                      input logic rq, input logic dr, input logic [31:0] ln,
                      input string tag);
    logic        is_cmd, go, hit, drained;
    logic [31:0] glen;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_idx = idx; reg_wdata = wd;
    core_irq = ci; core_done = cd; xfer_req = rq; xfer_dir = dr; xfer_len = ln;
    #1;
    is_cmd  = wr && (idx == 4'd0);
    go      = rq && (dr == m_cmd[7]) && !is_cmd;
    glen    = min_len(ln, m_wcnt);
    drained = go && (glen == m_wcnt);
    chk(tag, reg_rdata, model_read(idx, ci));
    chk("R8 grant", {31'd0, xfer_grant}, {31'd0, go});
    if (go) chk("R9 length", xfer_grant_len, glen);
    chk("R11 irq", {31'd0, irq}, {31'd0, ci | (m_stat[3] & m_cmd[6])});
    chk("R2 dma_en", {31'd0, dma_en}, {31'd0, m_en});
    chk("R2 abort", {31'd0, abort_pulse}, {31'd0, m_abort});
    @(posedge clk);
    // model update: clear first, set second
    hit = (idx == 4'd5);
    if (wr && hit && !m_bctl[12]) m_stat = m_stat & ~(wd[7:0] & 8'h0E);
    if (rd && hit && m_bctl[12])  m_stat = m_stat & ~8'h0E;
    m_abort = is_cmd && (wd[1:0] == 2'd2);
    if (is_cmd && wd[1:0] == 2'd3) begin
      m_wcnt = m_scnt; m_wadr = m_sadr; m_wdesc = m_sdesc;
      m_stat = m_stat & 8'hC0;
      m_en = 1'b1;
    end else begin
      if (cd)      m_wcnt = 0;
      else if (go) m_wcnt = m_wcnt - glen;
      if (go)      m_wadr = m_wadr + glen;
      if (cd || drained) m_stat[3] = 1'b1;
      if (is_cmd && wd[1:0] == 2'd0) m_en = 1'b0;
    end
    if (wr) begin
      case (idx)
        4'd0: m_cmd = wd;
        4'd1: m_scnt = wd;
        4'd2: m_sadr = wd;
        4'd6: m_sdesc = wd;
        4'd8: m_bctl = wd;
        default: ;
      endcase
    end
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [31:0] wd, input string tag);
    step(1, 0, idx, wd, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rd_reg(input logic [3:0] idx, input string tag);
    step(0, 1, idx, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int i = 0; i < 10; i++) rd_reg(i[3:0], "R1 reset readback");
    // R4 starting registers writable, working ones ignored
    wr_reg(4'd1, 32'd10, "R4");
    wr_reg(4'd2, 32'h1000, "R4");
    wr_reg(4'd6, 32'h2000, "R4");
    wr_reg(4'd3, 32'd5, "R4");
    wr_reg(4'd4, 32'h55, "R4");
    wr_reg(4'd7, 32'h77, "R4");
    rd_reg(4'd3, "R4 wcnt unchanged");
    rd_reg(4'd7, "R4 wdesc unchanged");
    // R3 START with done interrupt enable, dir 0
    wr_reg(4'd0, 32'h43, "R3");
    rd_reg(4'd3, "R3 wcnt load");
    rd_reg(4'd4, "R3 wadr load");
    rd_reg(4'd7, "R3 wdesc load");
    // R8 mismatched direction
    step(0, 0, 4'd3, 0, 0, 0, 1, 1, 32'd3, "R8 wcnt after drop");
    // R9 clamp and advance
    step(0, 0, 4'd3, 0, 0, 0, 1, 0, 32'd4, "R9");
    rd_reg(4'd4, "R9 wadr advanced");
    step(0, 0, 4'd3, 0, 0, 0, 1, 0, 32'd20, "R9 clamp");
    rd_reg(4'd5, "R10 done after drain");
    rd_reg(4'd5, "R11 irq with done");
    // R5 write-one clear
    wr_reg(4'd5, 32'h08, "R5");
    rd_reg(4'd5, "R5 cleared");
    // R7 live core interrupt bit
    step(0, 1, 4'd5, 0, 1, 0, 0, 0, 0, "R7 live bit");
    // R2 flush, abort, idle
    wr_reg(4'd0, 32'h41, "R2 flush");
    wr_reg(4'd0, 32'h42, "R2 abort");
    rd_reg(4'd0, "R2 abort pulse");
    wr_reg(4'd0, 32'h40, "R2 idle");
    rd_reg(4'd0, "R2 idle");
    // R6 read-to-clear mode
    wr_reg(4'd8, 32'h1000, "R6");
    step(0, 0, 4'd5, 0, 0, 1, 0, 0, 0, "R10 completion");
    wr_reg(4'd5, 32'hFF, "R6 write ignored");
    rd_reg(4'd5, "R6 read returns done");
    rd_reg(4'd5, "R6 read cleared");
    // R12 collisions
    step(0, 1, 4'd5, 0, 0, 1, 0, 0, 0, "R12 done vs read clear");
    rd_reg(4'd5, "R12 done kept");
    wr_reg(4'd8, 32'h0, "R12");
    step(1, 0, 4'd5, 32'h0E, 0, 1, 0, 0, 0, "R12 done vs write clear");
    rd_reg(4'd5, "R12 done kept");
    step(1, 0, 4'd0, 32'h03, 0, 1, 1, 0, 32'd2, "R12 start vs completion");
    rd_reg(4'd3, "R12 wcnt equals start count");
    rd_reg(4'd5, "R12 status cleared");
    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic        w, r, ci, cd, rq, dr;
      logic [3:0]  ix;
      logic [31:0] wd, ln;
      w  = ($urandom % 4) == 0;
      r  = ($urandom % 3) == 0;
      ix = 4'($urandom % 10);
      case (ix)
        4'd0:    wd = {$urandom} & 32'h0000_00FF;
        4'd1:    wd = $urandom % 48;
        4'd8:    wd = (($urandom % 2) << 12) | ($urandom & 32'hFFFF_EFFF);
        default: wd = $urandom;
      endcase
      ci = ($urandom % 5) == 0;
      cd = ($urandom % 40) == 0;
      rq = ($urandom % 2) == 0;
      dr = ($urandom % 4) == 0 ? ~m_cmd[7] : m_cmd[7];
      ln = $urandom % 20;
      step(w, r, ix, wd, ci, cd, rq, dr, ln, ix == 4'd5 ? "R5 R6 R7 status" : "R4 readback");
    end
    finish_run();
  end

endmodule